// File: doc/BRIEF.md
# Pin-Event Timer Capture Unit

This block snapshots a free-running 16-bit timer into a holding register whenever a chosen event happens on one asynchronous input pin. A 4-bit mode code picks the event: a falling edge, a rising edge, or one in every four or every sixteen rising edges. Each snapshot raises a sticky interrupt flag, which software drops with a one-cycle clear strobe.

The pin is brought into the clock domain by a two-flop synchronizer. Edges are found by comparing the synchronized sample with the sample taken one cycle earlier. A rising-edge counter implements the divide-by-4 and divide-by-16 options. The counter restarts from zero whenever the mode code changes. Mode 0000 switches the unit off and wipes the holding register, the flag and the counter. Any other code that is not a capture code also stops captures, but it leaves the holding register and the flag untouched.

Top module: `pin_capture_unit`

## Requirements
- R1: A pin transition reaches the outputs on the third rising clock edge after it is applied. After two edges the outputs still show the old state.
- R2: In mode 4'b0101, each rising edge of the pin loads the current timer value into capValue. Falling edges have no effect.
- R3: In mode 4'b0100, each falling edge of the pin loads the timer value. Rising edges have no effect.
- R4: In mode 4'b0110, a capture happens only on every 4th rising edge, counted from the last capture or from the last counter clear.
- R5: In mode 4'b0111, a capture happens only on every 16th rising edge, counted in the same way.
- R6: capFlag goes to 1 in the same clock edge that loads capValue. It then stays at 1 until flagClr is sampled high.
- R7: If flagClr is high in the cycle in which a capture happens, the capture wins and capFlag stays at 1.
- R8: Mode 4'b0000 clears capValue to 0, clears capFlag to 0 and clears the edge counter. Reset does the same.
- R9: Any mode code other than 0000, 0100, 0101, 0110 and 0111 performs no capture. In such a mode, capValue and capFlag keep their values.
- R10: A change of the mode code clears the edge counter. No capture happens in the cycle of the change.
- R11: flagClr with no capture in the same cycle clears capFlag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerVal | input | 16 | Current value of the free-running timer |
| pinIn | input | 1 | Asynchronous event pin |
| modeSel | input | 4 | Event-selection mode code |
| flagClr | input | 1 | One-cycle strobe that clears the flag |
| capValue | output | 16 | Last captured timer value |
| capFlag | output | 1 | Sticky capture interrupt flag |

## Verification
Most internal faults here show up as a wrong capture count. A counter that is not cleared, or that is off by one, makes the flag rise one or more edges too early or too late in the prescaled modes. The bench sees this within a few pin periods, because it checks the flag after every single edge of a 4-edge and a 16-edge sequence. A faulty synchronizer depth or edge polarity moves the flag by whole cycles or makes it fire on the wrong transition, so the bench checks the flag cycle by cycle. Faults in the wipe path or the clear priority show up as a stale capValue or flag one edge after the mode change or the strobe.

// File: rtl/capt_pkg.sv
package capt_pkg;
  localparam logic [3:0] MODE_OFF    = 4'b0000;
  localparam logic [3:0] MODE_FALL   = 4'b0100;
  localparam logic [3:0] MODE_RISE   = 4'b0101;
  localparam logic [3:0] MODE_RISE4  = 4'b0110;
  localparam logic [3:0] MODE_RISE16 = 4'b0111;

  typedef struct packed {
    logic load;   // copy timer value and raise flag
    logic wipe;   // off mode: clear register and flag
  } capStrobe_t;
endpackage

// File: rtl/capt_ctrl.sv
module capt_ctrl
  import capt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 4,
  parameter int DIV_HI      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic [3:0] modeSel,
  output capStrobe_t strb
);
  localparam int CNT_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncPin, prevPin;
  logic [3:0]             prevMode;
  logic [CNT_W-1:0]       edgeCnt, lastCnt;
  logic                   riseEdge, fallEdge, evt, isCapMode, modeChg, hitLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
      prevPin   <= 1'b0;
      prevMode  <= MODE_OFF;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
      prevPin   <= syncPin;
      prevMode  <= modeSel;
    end
  end

  assign syncPin   = syncChain[SYNC_STAGES-1];
  assign riseEdge  = syncPin & ~prevPin;
  assign fallEdge  = ~syncPin & prevPin;
  assign isCapMode = (modeSel[3:2] == 2'b01);
  assign modeChg   = (modeSel != prevMode);
  assign evt       = (modeSel == MODE_FALL) ? fallEdge : riseEdge;

  always_comb begin
    case (modeSel)
      MODE_RISE4:  lastCnt = CNT_W'(DIV_LO - 1);
      MODE_RISE16: lastCnt = CNT_W'(DIV_HI - 1);
      default:     lastCnt = '0;
    endcase
  end

  assign hitLast   = (edgeCnt == lastCnt);
  assign strb.load = isCapMode && !modeChg && evt && hitLast;
  assign strb.wipe = (modeSel == MODE_OFF);

  always_ff @(posedge clk) begin
    if (!rstN || !isCapMode || modeChg) edgeCnt <= '0;
    else if (evt) edgeCnt <= hitLast ? '0 : edgeCnt + 1'b1;
  end

  p_mode_change_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> (edgeCnt == '0));
  p_off_clears_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_OFF) |=> (edgeCnt == '0));
  p_fall_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && modeSel == MODE_FALL) |-> (!syncPin && $past(syncPin)));
  p_rise_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && modeSel == MODE_RISE) |-> (syncPin && !$past(syncPin)));
  p_div4_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && modeSel == MODE_RISE4) |-> (edgeCnt == CNT_W'(DIV_LO - 1)));
  p_div16_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && modeSel == MODE_RISE16) |-> (edgeCnt == CNT_W'(DIV_HI - 1)));
  p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.wipe}));
endmodule

// File: rtl/capt_datapath.sv
module capt_datapath
  import capt_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic               flagClr,
  input  capStrobe_t         strb,
  output logic [TIMER_W-1:0] capValue,
  output logic               capFlag
);
  always_ff @(posedge clk) begin
    if (!rstN || strb.wipe) begin
      capValue <= '0;
      capFlag  <= 1'b0;
    end else begin
      if (strb.load) capValue <= timerVal;
      if (strb.load)    capFlag <= 1'b1;
      else if (flagClr) capFlag <= 1'b0;
    end
  end

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (capValue == $past(timerVal)));
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClr && !strb.wipe) |=> capFlag);
  p_capture_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && flagClr) |=> capFlag);
  p_wipe_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipe |=> (capValue == '0 && !capFlag));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.wipe) |=> $stable(capValue));
  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !strb.load) |=> !capFlag);
endmodule

// File: rtl/pin_capture_unit.sv
module pin_capture_unit
  import capt_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 4,
  parameter int DIV_HI      = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic               pinIn,
  input  logic [3:0]         modeSel,
  input  logic               flagClr,
  output logic [TIMER_W-1:0] capValue,
  output logic               capFlag
);
  capStrobe_t strb;

  capt_ctrl #(.SYNC_STAGES(SYNC_STAGES), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .modeSel(modeSel), .strb(strb)
  );

  capt_datapath #(.TIMER_W(TIMER_W)) u_dp (
    .clk(clk), .rstN(rstN), .timerVal(timerVal), .flagClr(flagClr),
    .strb(strb), .capValue(capValue), .capFlag(capFlag)
  );
endmodule

// File: tb/pin_capture_unit_bench.sv
module pin_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] timerVal = '0;
  logic        pinIn = 1'b0;
  logic [3:0]  modeSel = 4'b0101;
  logic        flagClr = 1'b0;
  logic [15:0] capValue;
  logic        capFlag;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pin_capture_unit u_pin_capture_unit (
    .clk(clk), .rstN(rstN), .timerVal(timerVal), .pinIn(pinIn),
    .modeSel(modeSel), .flagClr(flagClr), .capValue(capValue), .capFlag(capFlag)
  );

  typedef struct packed {
    logic [3:0]  m;
    logic [15:0] t;
    logic        p;
    logic        c;
    logic [15:0] ec;
    logic        ef;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'b0101, 16'h1111, 1'b1, 1'b0, 16'h1111, 1'b1},  // R2 rise
    '{4'b0101, 16'h2222, 1'b0, 1'b0, 16'h1111, 1'b1},  // R2 fall ignored
    '{4'b0101, 16'h3333, 1'b0, 1'b1, 16'h1111, 1'b0},  // R11 clear
    '{4'b0100, 16'h4444, 1'b1, 1'b0, 16'h1111, 1'b0},  // R3 rise ignored
    '{4'b0100, 16'h5555, 1'b0, 1'b0, 16'h5555, 1'b1},  // R3 fall
    '{4'b0100, 16'h6666, 1'b1, 1'b1, 16'h5555, 1'b0},
    '{4'b0110, 16'h7001, 1'b0, 1'b0, 16'h5555, 1'b0},  // R4 start
    '{4'b0110, 16'h7002, 1'b1, 1'b0, 16'h5555, 1'b0},
    '{4'b0110, 16'h7003, 1'b0, 1'b0, 16'h5555, 1'b0},
    '{4'b0110, 16'h7004, 1'b1, 1'b0, 16'h5555, 1'b0},
    '{4'b0110, 16'h7005, 1'b0, 1'b0, 16'h5555, 1'b0},
    '{4'b0110, 16'h7006, 1'b1, 1'b0, 16'h5555, 1'b0},
    '{4'b0110, 16'h7007, 1'b0, 1'b0, 16'h5555, 1'b0},
    '{4'b0110, 16'h7008, 1'b1, 1'b0, 16'h7008, 1'b1},  // R4 4th edge
    '{4'b1010, 16'h9999, 1'b0, 1'b0, 16'h7008, 1'b1},  // R9 reserved
    '{4'b1010, 16'hAAAA, 1'b1, 1'b0, 16'h7008, 1'b1},  // R9
    '{4'b0000, 16'hBBBB, 1'b0, 1'b0, 16'h0000, 1'b0}   // R8 off
  };

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive inputs, optional one-cycle clear, then wait four edges in total
  task automatic apply(input logic [3:0] m, input logic [15:0] t, input logic p, input logic c);
    @(negedge clk);
    modeSel = m; timerVal = t; pinIn = p; flagClr = c;
    @(negedge clk);
    flagClr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R8 reset state", {capValue, capFlag}, {16'h0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].m, VEC[i].t, VEC[i].p, VEC[i].c);
      chk($sformatf("R2/R3/R4/R8/R9/R11 vector %0d", i),
          {capValue, capFlag}, {VEC[i].ec, VEC[i].ef});
    end

    // R1 latency, rising mode
    apply(4'b0101, 16'h1234, 1'b0, 1'b0);
    pinIn = 1'b1;
    @(negedge clk);
    chk("R1 after one edge", {16'h0, capFlag}, {16'h0, 1'b0});
    @(negedge clk);
    chk("R1 after two edges", {capValue, capFlag}, {16'h0, 1'b0});
    @(negedge clk);
    chk("R1 after three edges", {capValue, capFlag}, {16'h1234, 1'b1});

    // R7 capture and clear in the same cycle
    apply(4'b0101, 16'h4321, 1'b0, 1'b0);
    pinIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    chk("R7 capture beats clear", {capValue, capFlag}, {16'h4321, 1'b1});
    // R6 flag stays up with no clear
    repeat (5) @(negedge clk);
    chk("R6 flag sticky", {capValue, capFlag}, {16'h4321, 1'b1});
    apply(4'b0101, 16'h4321, 1'b0, 1'b1);
    chk("R11 clear alone", {16'h0, capFlag}, {16'h0, 1'b0});

    // R5 every 16th rising edge
    apply(4'b0111, 16'h0001, 1'b0, 1'b0);
    for (int k = 1; k <= 15; k++) begin
      apply(4'b0111, 16'h0100 + 16'(k), 1'b1, 1'b0);
      chk($sformatf("R5 no capture at edge %0d", k), {16'h0, capFlag}, {16'h0, 1'b0});
      apply(4'b0111, 16'h0200, 1'b0, 1'b0);
    end
    apply(4'b0111, 16'hBEEF, 1'b1, 1'b0);
    chk("R5 capture at edge 16", {capValue, capFlag}, {16'hBEEF, 1'b1});
    apply(4'b0111, 16'h0000, 1'b0, 1'b1);

    // R10 mode change restarts the count
    apply(4'b0110, 16'h0A01, 1'b1, 1'b0);
    apply(4'b0110, 16'h0A02, 1'b0, 1'b0);
    apply(4'b0110, 16'h0A03, 1'b1, 1'b0);
    apply(4'b0110, 16'h0A04, 1'b0, 1'b0);
    apply(4'b0111, 16'h0A05, 1'b0, 1'b0);
    apply(4'b0110, 16'h0A06, 1'b0, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      apply(4'b0110, 16'h0C00 + 16'(k), 1'b1, 1'b0);
      chk($sformatf("R10 no capture at edge %0d after change", k),
          {capValue, capFlag}, {16'hBEEF, 1'b0});
      apply(4'b0110, 16'h0D00, 1'b0, 1'b0);
    end
    apply(4'b0110, 16'hCAFE, 1'b1, 1'b0);
    chk("R10 capture at 4th edge after change", {capValue, capFlag}, {16'hCAFE, 1'b1});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule